// File: doc/BRIEF.md
# Transmit Byte Path with Priority Queue and Substitution

This block sits between the host-facing transmit storage of one serial channel and its bit serializer. Bytes arrive into one of two queues: a deep normal queue and a shallow priority queue whose contents always jump ahead of queued normal data. Each byte taken from a queue passes a compare stage that can check it against two programmable values. A match on the first value can drop the byte, pass it unchanged, or expand it into a programmed pair of bytes. A match on the second value can drop it or swap it for one programmed byte.

A transmit enable decides whether bytes are taken from the queues into the one-byte holding stage. A CTS gate and a software transmit-off condition, which an override input can defeat, decide whether the held byte is offered to the serializer. The serializer side is a valid/ready byte stream, and a byte leaves the holding stage only on a handshake.

Top module: `txsub_top`

## Requirements
- R1: The normal queue holds NORM_DEPTH bytes and `norm_count` reports its occupancy; a write while it is full is discarded and the occupancy stays the same.
- R2: The priority queue holds PRI_DEPTH bytes (PRI_DEPTH at most 127); `pri_status` bits 6:0 give its occupancy and bit 7 is 1 exactly when it is not empty; a write while it is full is discarded.
- R3: Whenever the priority queue is not empty, the next byte taken into the holding stage comes from it, never from the normal queue.
- R4: With `sub_ctrl` bit 0 (compare 1 enable) and bit 4 (pair replace) set and bit 2 clear, a byte equal to `cmp1_val` is emitted as `pair_first` followed directly by `pair_second`; no other byte, priority bytes included, is emitted between the two.
- R5: With `sub_ctrl` bit 1 (compare 2 enable) set and bit 3 clear, a byte equal to `cmp2_val` that does not take the compare 1 path is emitted as `swap_val`.
- R6: `sub_ctrl` bit 2 drops a compare 1 match and bit 3 drops a compare 2 match, with nothing emitted; a drop takes precedence over replacement for the same value.
- R7: Compare 1 is evaluated first: a byte matching both enabled values follows the compare 1 rules only; a compare 1 match with bits 2 and 4 clear passes unchanged; bytes matching no enabled value pass unchanged.
- R8: While `tx_en` is low no byte is taken from either queue, but the bytes already in the holding stage (at most two, when a pair is in progress) are still emitted.
- R9: `ser_valid` is low while `cts_gate_en` is high and `cts_in` is low, and while `xoff_active` is high and `xoff_override` is low.
- R10: A byte is consumed only when `ser_valid` and `ser_ready` are both high; while `ser_ready` is low an offered byte stays on `ser_data` unchanged.
- R11: After reset both queues are empty, `norm_count` and `pri_status` read 0 and `ser_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_wr | input | 1 | Write a byte into the normal queue |
| norm_data | input | 8 | Byte for the normal queue |
| norm_full | output | 1 | Normal queue is full |
| norm_count | output | $clog2(NORM_DEPTH+1) | Normal queue occupancy |
| pri_wr | input | 1 | Write a byte into the priority queue |
| pri_data | input | 8 | Byte for the priority queue |
| pri_full | output | 1 | Priority queue is full |
| pri_status | output | 8 | Bit 7 pending flag, bits 6:0 priority occupancy |
| tx_en | input | 1 | Allows bytes to move from the queues into the holding stage |
| cts_gate_en | input | 1 | Enables gating of output by CTS |
| cts_in | input | 1 | Clear-to-send input, high means clear |
| xoff_active | input | 1 | Software transmit-off condition |
| xoff_override | input | 1 | Defeats the software transmit-off condition |
| sub_ctrl | input | 5 | Compare/substitute control, bit meanings in R4 to R7 |
| cmp1_val | input | 8 | Compare value 1 |
| cmp2_val | input | 8 | Compare value 2 |
| pair_first | input | 8 | First byte replacing a compare 1 match |
| pair_second | input | 8 | Second byte replacing a compare 1 match |
| swap_val | input | 8 | Byte replacing a compare 2 match |
| ser_valid | output | 1 | A byte is offered to the serializer |
| ser_data | output | 8 | Offered byte |
| ser_ready | input | 1 | Serializer accepts the offered byte |

## Verification
The bench builds the block with NORM_DEPTH = 6 and PRI_DEPTH = 3 instead of the large defaults, so both queues overflow within a handful of writes and the discarded-write and full-flag corners are hit repeatedly in every phase. With shallow queues the priority queue empties and refills often, which brings the ordering between priority and normal bytes, and the interplay with an in-progress replacement pair, into many short episodes rather than one long one. Stimulus draws bytes mostly from the two compare values so that every substitution rule fires many times against random back-pressure and gating.

// File: rtl/txsub_pkg.sv
package txsub_pkg;

  // Action taken on a byte leaving a queue.
  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_DROP = 2'd1,
    ACT_SWAP = 2'd2,
    ACT_PAIR = 2'd3
  } act_e;

  // Control byte layout: bit 4 pair replace, bit 3 drop on value 2,
  // bit 2 drop on value 1, bit 1 compare 2 enable, bit 0 compare 1 enable.
  typedef struct packed {
    logic pair1;
    logic drop2;
    logic drop1;
    logic cmp2_en;
    logic cmp1_en;
  } subctl_t;

  // Compare 1 is checked first; dropping beats replacing.
  function automatic act_e classify(input logic [7:0] b, input subctl_t c,
                                    input logic [7:0] v1, input logic [7:0] v2);
    if (c.cmp1_en && (b == v1)) begin
      if (c.drop1) return ACT_DROP;
      if (c.pair1) return ACT_PAIR;
      return ACT_PASS;
    end
    if (c.cmp2_en && (b == v2)) begin
      if (c.drop2) return ACT_DROP;
      return ACT_SWAP;
    end
    return ACT_PASS;
  endfunction

  // Output may be offered only when neither CTS nor software-off holds it.
  function automatic logic flow_open(input logic cts_gate, input logic cts,
                                     input logic xoff, input logic ovr);
    return !(cts_gate && !cts) && !(xoff && !ovr);
  endfunction

endpackage

// File: rtl/txsub_fifo.sv
module txsub_fifo #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    wdata,
  input  logic          rd,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign push  = wr && !full;
  assign pop   = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R1 (and R2 for the priority instance): a write into a full queue is lost.
  a_r1_full_write_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (count == $past(count)));

  a_r1_never_above_depth: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/txsub_hold.sv
module txsub_hold
  import txsub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flow_ok,
  input  logic       ser_ready,
  input  logic       load,
  input  act_e       act,
  input  logic [7:0] byte_in,
  input  logic [7:0] pair_first,
  input  logic [7:0] pair_second,
  input  logic [7:0] swap_val,
  output logic       take_ok,
  output logic       ser_valid,
  output logic [7:0] ser_data
);
  logic       out_valid, sec_valid;
  logic [7:0] out_data,  sec_data;
  logic       fire;

  assign fire      = out_valid && flow_ok && ser_ready;
  assign take_ok   = !sec_valid && (!out_valid || fire);
  assign ser_valid = out_valid && flow_ok;
  assign ser_data  = out_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sec_valid <= 1'b0;
      out_data  <= '0;
      sec_data  <= '0;
    end else begin
      if (fire) out_valid <= 1'b0;
      if (sec_valid && fire) begin
        out_data  <= sec_data;
        out_valid <= 1'b1;
        sec_valid <= 1'b0;
      end else if (load) begin
        unique case (act)
          ACT_PASS: begin out_data <= byte_in;  out_valid <= 1'b1; end
          ACT_SWAP: begin out_data <= swap_val; out_valid <= 1'b1; end
          ACT_PAIR: begin
            out_data  <= pair_first;
            out_valid <= 1'b1;
            sec_data  <= pair_second;
            sec_valid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: nothing enters while the second byte of a pair waits.
  a_r4_pair_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> !load);

  // R10: an offered byte stays put until it is taken.
  a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (!ser_valid || $stable(ser_data)));

  // R9: a closed flow gate never offers a byte.
  a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_ok |-> !ser_valid);

endmodule

// File: rtl/txsub_top.sv
module txsub_top
  import txsub_pkg::*;
#(
  parameter int NORM_DEPTH = 255,
  parameter int PRI_DEPTH  = 32,
  localparam int NCW = $clog2(NORM_DEPTH + 1),
  localparam int PCW = $clog2(PRI_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           norm_wr,
  input  logic [7:0]     norm_data,
  output logic           norm_full,
  output logic [NCW-1:0] norm_count,
  input  logic           pri_wr,
  input  logic [7:0]     pri_data,
  output logic           pri_full,
  output logic [7:0]     pri_status,
  input  logic           tx_en,
  input  logic           cts_gate_en,
  input  logic           cts_in,
  input  logic           xoff_active,
  input  logic           xoff_override,
  input  logic [4:0]     sub_ctrl,
  input  logic [7:0]     cmp1_val,
  input  logic [7:0]     cmp2_val,
  input  logic [7:0]     pair_first,
  input  logic [7:0]     pair_second,
  input  logic [7:0]     swap_val,
  output logic           ser_valid,
  output logic [7:0]     ser_data,
  input  logic           ser_ready
);
  logic [7:0]     norm_head, pri_head, pick;
  logic [PCW-1:0] pri_count;
  logic           norm_empty, pri_empty;
  logic           take_ok, load, norm_pop, pri_pop, flow_ok;
  act_e           act;

  txsub_fifo #(.DEPTH(NORM_DEPTH)) i_norm (
    .clk(clk), .rst_n(rst_n), .wr(norm_wr), .wdata(norm_data),
    .rd(norm_pop), .rdata(norm_head), .count(norm_count),
    .empty(norm_empty), .full(norm_full));

  txsub_fifo #(.DEPTH(PRI_DEPTH)) i_pri (
    .clk(clk), .rst_n(rst_n), .wr(pri_wr), .wdata(pri_data),
    .rd(pri_pop), .rdata(pri_head), .count(pri_count),
    .empty(pri_empty), .full(pri_full));

  assign pri_status = {!pri_empty, 7'(pri_count)};

  // Source selection: priority bytes always go first.
  assign load     = tx_en && take_ok && !(pri_empty && norm_empty);
  assign pri_pop  = load && !pri_empty;
  assign norm_pop = load && pri_empty;
  assign pick     = pri_empty ? norm_head : pri_head;
  assign act      = classify(pick, subctl_t'(sub_ctrl), cmp1_val, cmp2_val);
  assign flow_ok  = flow_open(cts_gate_en, cts_in, xoff_active, xoff_override);

  txsub_hold i_hold (
    .clk(clk), .rst_n(rst_n), .flow_ok(flow_ok), .ser_ready(ser_ready),
    .load(load), .act(act), .byte_in(pick),
    .pair_first(pair_first), .pair_second(pair_second), .swap_val(swap_val),
    .take_ok(take_ok), .ser_valid(ser_valid), .ser_data(ser_data));

  // R3: a normal byte is never taken while priority data is pending.
  a_r3_pri_first: assert property (@(posedge clk) disable iff (!rst_n)
    norm_pop |-> !pri_status[7]);

  // R8: a disabled transmitter takes nothing from the queues.
  a_r8_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !(norm_pop || pri_pop));

  // R9: CTS gating seen at the ports.
  a_r9_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate_en && !cts_in) |-> !ser_valid);

  // R2: pending flag tracks a non-zero priority count.
  a_r2_pending_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pri_wr && !pri_full |=> pri_status[7]);

  initial begin
    a_r2_depth_fits: assert (PRI_DEPTH <= 127 && PRI_DEPTH >= 1);
  end

endmodule

// File: tb/test_txsub_top.sv
module test_txsub_top;
  localparam int ND  = 6;
  localparam int PD  = 3;
  localparam int NCW = $clog2(ND + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic norm_wr = 0, pri_wr = 0, tx_en = 0, cts_gate_en = 0, cts_in = 1;
  logic xoff_active = 0, xoff_override = 0, ser_ready = 0;
  logic [7:0] norm_data = 0, pri_data = 0;
  logic [4:0] sub_ctrl = 0;
  logic [7:0] cmp1_val = 8'h11, cmp2_val = 8'h13, pair_first = 8'h0D, pair_second = 8'h0A, swap_val = 8'h2E;
  logic           norm_full, pri_full, ser_valid;
  logic [NCW-1:0] norm_count;
  logic [7:0]     pri_status, ser_data;

  always #10 clk = ~clk;

  txsub_top #(.NORM_DEPTH(ND), .PRI_DEPTH(PD)) i_txsub_top (
    .clk(clk), .rst_n(rst_n), .norm_wr(norm_wr), .norm_data(norm_data),
    .norm_full(norm_full), .norm_count(norm_count), .pri_wr(pri_wr),
    .pri_data(pri_data), .pri_full(pri_full), .pri_status(pri_status),
    .tx_en(tx_en), .cts_gate_en(cts_gate_en), .cts_in(cts_in),
    .xoff_active(xoff_active), .xoff_override(xoff_override),
    .sub_ctrl(sub_ctrl), .cmp1_val(cmp1_val), .cmp2_val(cmp2_val),
    .pair_first(pair_first), .pair_second(pair_second), .swap_val(swap_val),
    .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready));

  int n_tests = 0, n_fail = 0;
  string cur = "R11";

  // reference model state
  byte unsigned nq[$];
  byte unsigned pq[$];
  bit           m_vld = 0, m_sec = 0;
  byte unsigned m_dat = 0, m_sdat = 0;

  // stimulus knobs (percent)
  int p_norm = 0, p_pri = 0, p_rdy = 100, p_en = 100;
  bit rnd_gate = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit gate_open();
    bit cts_hold = cts_gate_en && !cts_in;
    bit sw_hold  = xoff_active && !xoff_override;
    return !cts_hold && !sw_hold;
  endfunction

  function automatic byte unsigned pick_byte();
    int k = $urandom_range(0, 3);
    if (k == 0) return cmp1_val;
    if (k == 1) return cmp2_val;
    return byte'($urandom_range(0, 255));
  endfunction

  // next state of the model, given the inputs now applied
  task automatic model_step();
    bit go   = m_vld && ser_ready && gate_open();
    bit room = tx_en && !m_sec && (!m_vld || go);
    bit acc_n = norm_wr && (nq.size() < ND);
    bit acc_p = pri_wr && (pq.size() < PD);
    byte unsigned b;
    if (go) m_vld = 0;
    if (m_sec && go) begin
      m_dat = m_sdat; m_vld = 1; m_sec = 0;
    end else if (room && (pq.size() > 0 || nq.size() > 0)) begin
      if (pq.size() > 0) b = pq.pop_front(); else b = nq.pop_front();
      if (sub_ctrl[0] && b == cmp1_val) begin
        if (sub_ctrl[2]) ;
        else if (sub_ctrl[4]) begin m_dat = pair_first; m_sdat = pair_second; m_sec = 1; m_vld = 1; end
        else begin m_dat = b; m_vld = 1; end
      end else if (sub_ctrl[1] && b == cmp2_val) begin
        if (!sub_ctrl[3]) begin m_dat = swap_val; m_vld = 1; end
      end else begin
        m_dat = b; m_vld = 1;
      end
    end
    if (acc_n) nq.push_back(norm_data);
    if (acc_p) pq.push_back(pri_data);
  endtask

  task automatic compare_outputs();
    int exp_pri = (pq.size() > 0 ? 128 : 0) + pq.size();
    check(cur, int'(ser_valid), int'(m_vld && gate_open()), "ser_valid");
    if (m_vld && gate_open()) check(cur, int'(ser_data), int'(m_dat), "ser_data");
    check(cur, int'(norm_count), nq.size(), "norm_count");
    check(cur, int'(pri_status), exp_pri, "pri_status");
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_outputs();
      norm_wr   = ($urandom_range(0, 99) < p_norm);
      pri_wr    = ($urandom_range(0, 99) < p_pri);
      norm_data = pick_byte();
      pri_data  = pick_byte();
      ser_ready = ($urandom_range(0, 99) < p_rdy);
      tx_en     = ($urandom_range(0, 99) < p_en);
      if (rnd_gate) begin
        cts_gate_en   = $urandom_range(0, 1);
        cts_in        = $urandom_range(0, 1);
        xoff_active   = $urandom_range(0, 1);
        xoff_override = $urandom_range(0, 1);
      end
      model_step();
    end
  endtask

  task automatic drain(input int cycles);
    p_norm = 0; p_pri = 0; p_rdy = 100; p_en = 100; rnd_gate = 0;
    cts_gate_en = 0; xoff_active = 0;
    run(cycles);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11: reset state
    cur = "R11";
    @(negedge clk);
    check("R11", int'(ser_valid), 0, "ser_valid after reset");
    check("R11", int'(norm_count), 0, "norm_count after reset");
    check("R11", int'(pri_status), 0, "pri_status after reset");

    // R1: overfill the normal queue with the transmitter disabled
    cur = "R1"; p_en = 0; p_norm = 100; p_pri = 0; run(12);
    check("R1", int'(norm_full), 1, "norm_full after overfill");
    check("R1", int'(norm_count), ND, "norm_count after overfill");
    drain(20);

    // R2: overfill the priority queue
    cur = "R2"; p_en = 0; p_pri = 100; run(8);
    check("R2", int'(pri_status), 128 + PD, "pri_status after overfill");
    drain(15);

    // R3: both queues loaded, then released
    cur = "R3"; p_en = 0; p_norm = 100; p_pri = 100; run(6);
    p_en = 100; p_norm = 40; p_pri = 30; run(60);
    drain(20);

    // R4: pair replacement under back-pressure, priority traffic alongside
    cur = "R4"; sub_ctrl = 5'b10001; p_norm = 60; p_pri = 25; p_rdy = 60; run(150);
    drain(25);

    // R5: single-byte swap on value 2
    cur = "R5"; sub_ctrl = 5'b00010; p_norm = 60; p_pri = 20; p_rdy = 70; run(100);
    drain(25);

    // R6: drops win over replacement
    cur = "R6"; sub_ctrl = 5'b11111; p_norm = 70; p_pri = 20; p_rdy = 70; run(80);
    sub_ctrl = 5'b01010; run(60);
    drain(25);

    // R7: compare order and pass-through cases
    cur = "R7"; cmp2_val = cmp1_val; sub_ctrl = 5'b10011; p_norm = 60; p_pri = 20; p_rdy = 70; run(80);
    cmp2_val = 8'h13; sub_ctrl = 5'b00001; run(50);
    sub_ctrl = 5'b00000; run(50);
    drain(25);

    // R8: transmit enable toggling with pairs in flight
    cur = "R8"; sub_ctrl = 5'b10001; p_norm = 60; p_pri = 20; p_rdy = 60; p_en = 40; run(200);
    drain(25);

    // R9: CTS and software-off gating
    cur = "R9"; sub_ctrl = 5'b10011; p_norm = 60; p_pri = 20; p_rdy = 80; rnd_gate = 1; run(200);
    drain(25);

    // R10: sparse ready, offered byte must hold
    cur = "R10"; sub_ctrl = 5'b10010; p_norm = 50; p_pri = 20; p_rdy = 25; run(200);
    drain(40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule